// File: doc/BRIEF.md
# Serial Configuration Port Slave

This block lets a host processor read and write a bank of 8-bit control registers over a synchronous serial link. Every access is one chip-select cycle. It opens with an instruction byte that gives the direction, the number of data bytes (one to four) and the first register address. The data bytes follow, and between bytes the port steps the register address on its own. The whole bank is also presented as one flat parallel vector, so neighbouring logic can use the settings directly.

Two bits of register 0 choose the framing. One selects the bit order, and the same bit also sets the direction of address stepping. Lowest-bit-first counts the address up and highest-bit-first counts it down. The other bit selects whether read data returns on the shared data line or on a separate output line. The port runs on a fast system clock. It synchronises the serial clock, chip select and data input, then detects the serial clock edges. Input bits are taken on the rising edge of the serial clock and read bits are launched on the falling edge. Both framing bits are captured when chip select goes active, so a change written to register 0 first applies to the next access.

Top module: `cfgSpiSlave`

## Requirements
- R1: After reset every register reads 0x00, both output enables are low, and the port uses highest-bit-first order with separate data-in and data-out lines.
- R2: The instruction byte, once assembled in the frame's bit order, carries read/write in bit 7 (1 = read), the data byte count minus one in bits 6:5, and the start register address in bits 4:0.
- R3: When register 0 bit 6 is 0, the instruction and data bytes move highest bit first, and the address goes down by one after each data byte, wrapping from 0 to 31.
- R4: When register 0 bit 6 is 1, the instruction and data bytes move lowest bit first, and the address goes up by one after each data byte, wrapping from 31 to 0.
- R5: During the data bytes of a read, a new read bit appears only after a falling serial clock edge and is held for the host to sample at the next rising edge. With register 0 bit 7 at 0, the bit is driven on sdoOut with sdoOe high, and sdioOe stays low.
- R6: With register 0 bit 7 at 1, read data is driven on sdioOut with sdioOe high and sdoOe stays low. The two enables are never high together.
- R7: Bytes clocked in after the counted data bytes of an access change no register, and no output enable rises during them.
- R8: Raising chip select ends the access at once. A partial byte is dropped without effect, both output enables fall, and the next access starts with an instruction byte.
- R9: A write to register 0 bits 7:6 leaves the bit order, step direction and read pin of the current access unchanged, and they take effect from the next chip-select cycle.
- R10: regFile bits 8i+7:8i show register i, and a completed write byte is visible there before chip select is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; serial inputs are oversampled with it |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdioIn | input | 1 | Serial data from the host (input side of the shared line) |
| sdioOut | output | 1 | Read data on the shared line when bidirectional mode is selected |
| sdioOe | output | 1 | Drive enable for the shared line |
| sdoOut | output | 1 | Read data on the separate output line |
| sdoOe | output | 1 | Drive enable for the separate output line |
| regFile | output | 256 | All registers, register i at bits 8i+7:8i |

## Verification
If the bit counter or the framing state is wrong, the error shows at the ports within one byte. Read bytes come back rotated or bit-reversed, or a write lands in the wrong regFile byte once that byte ends. If the address step is wrong, the error shows on the second byte of a multibyte access, since the byte goes to or comes from the neighbour on the wrong side. If the framing bits are captured at the wrong moment, the error shows in the bytes that follow a write to register 0 within the same access. If the abort path is wrong, the error shows in the first regFile check after a cut-short access, or in the very next instruction.

// File: rtl/cfgSpiPkg.sv
package cfgSpiPkg;

  // Instruction byte fields, as assembled (independent of wire order)
  localparam int INSTR_RW_BIT  = 7;
  localparam int INSTR_CNT_HI  = 6;
  localparam int INSTR_CNT_LO  = 5;
  localparam int INSTR_CNT_W   = INSTR_CNT_HI - INSTR_CNT_LO + 1;
  localparam int INSTR_ADDR_W  = INSTR_CNT_LO;

  // Framing control bits inside register 0
  localparam int MODE_LSB_BIT   = 6;
  localparam int MODE_BIDIR_BIT = 7;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic frameStart;   // chip select just became active
    logic bitIn;        // take one serial bit
    logic instrDone;    // the bit just taken completes the instruction
    logic dataDone;     // the bit just taken completes a counted data byte
    logic bitOut;       // launch the next read bit
  } cfgStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INSTR,
    ST_DATA,
    ST_DONE
  } cfgState_e;

endpackage

// File: rtl/cfgSpiSync.sv
module cfgSpiSync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= RESET_VAL;
        else       chain[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= RESET_VAL;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/cfgSpiCtrl.sv
module cfgSpiCtrl
  import cfgSpiPkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   csAct,
  input  logic                   sclkS,
  input  logic                   instrRead,
  input  logic [INSTR_CNT_W-1:0] instrCnt,
  output cfgStrobe_t             strb,
  output logic                   readPhase
);

  cfgState_e              state;
  logic                   sclkPrev;
  logic                   csPrev;
  logic [2:0]             bitCnt;
  logic [INSTR_CNT_W-1:0] bytesLeft;
  logic                   rdMode;

  logic riseDet, fallDet, lastBit, shifting;

  always_comb begin
    riseDet  = sclkS && !sclkPrev;
    fallDet  = !sclkS && sclkPrev;
    lastBit  = (bitCnt == 3'd7);
    shifting = csAct && (state == ST_INSTR || state == ST_DATA);

    strb.frameStart = csAct && !csPrev;
    strb.bitIn      = shifting && riseDet;
    strb.instrDone  = strb.bitIn && lastBit && (state == ST_INSTR);
    strb.dataDone   = strb.bitIn && lastBit && (state == ST_DATA);
    strb.bitOut     = csAct && fallDet && (state == ST_DATA) && rdMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      csPrev   <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      csPrev   <= csAct;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      bytesLeft <= '0;
      rdMode    <= 1'b0;
    end else if (!csAct) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      rdMode <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          state  <= ST_INSTR;
          bitCnt <= '0;
        end
        ST_INSTR: begin
          if (strb.bitIn) begin
            bitCnt <= bitCnt + 3'd1;
            if (lastBit) begin
              state     <= ST_DATA;
              bytesLeft <= instrCnt;
              rdMode    <= instrRead;
            end
          end
        end
        ST_DATA: begin
          if (strb.bitIn) begin
            bitCnt <= bitCnt + 3'd1;
            if (lastBit) begin
              if (bytesLeft == '0) begin
                state  <= ST_DONE;
                rdMode <= 1'b0;
              end else begin
                bytesLeft <= bytesLeft - 1'b1;
              end
            end
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  assign readPhase = rdMode;

endmodule

// File: rtl/cfgSpiData.sv
module cfgSpiData
  import cfgSpiPkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int NREG = 1 << ADDR_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  cfgStrobe_t             strb,
  input  logic                   sdiS,
  output logic                   instrRead,
  output logic [INSTR_CNT_W-1:0] instrCnt,
  output logic                   outBit,
  output logic                   lsbMode,
  output logic                   bidirMode,
  output logic [NREG*8-1:0]      regFlat
);

  logic [7:0]        regs [NREG];
  logic [7:0]        shReg;
  logic [7:0]        shNext;
  logic [7:0]        readSh;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] startAddr;
  logic              isWrite;

  always_comb begin
    shNext    = lsbMode ? {sdiS, shReg[7:1]} : {shReg[6:0], sdiS};
    instrRead = shNext[INSTR_RW_BIT];
    instrCnt  = shNext[INSTR_CNT_HI:INSTR_CNT_LO];
    startAddr = shNext[ADDR_W-1:0];
    nextAddr  = lsbMode ? addr + 1'b1 : addr - 1'b1;
  end

  // Input shift register and framing capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      lsbMode   <= 1'b0;
      bidirMode <= 1'b0;
    end else if (strb.frameStart) begin
      shReg     <= '0;
      lsbMode   <= regs[0][MODE_LSB_BIT];
      bidirMode <= regs[0][MODE_BIDIR_BIT];
    end else if (strb.bitIn) begin
      shReg <= shNext;
    end
  end

  // Address pointer and access direction
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr    <= '0;
      isWrite <= 1'b0;
    end else if (strb.instrDone) begin
      addr    <= startAddr;
      isWrite <= !shNext[INSTR_RW_BIT];
    end else if (strb.dataDone) begin
      addr <= nextAddr;
    end
  end

  // Register bank
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (strb.dataDone && isWrite) begin
      regs[addr] <= shNext;
    end
  end

  // Read shifter: loaded at byte boundaries, drained on falling edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readSh <= '0;
      outBit <= 1'b0;
    end else if (strb.frameStart) begin
      readSh <= '0;
      outBit <= 1'b0;
    end else if (strb.instrDone) begin
      readSh <= regs[startAddr];
    end else if (strb.dataDone) begin
      readSh <= regs[nextAddr];
    end else if (strb.bitOut) begin
      if (lsbMode) begin
        outBit <= readSh[0];
        readSh <= {1'b0, readSh[7:1]};
      end else begin
        outBit <= readSh[7];
        readSh <= {readSh[6:0], 1'b0};
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regFlat[g*8 +: 8] = regs[g];
  end

endmodule

// File: rtl/cfgSpiSlave.sv
module cfgSpiSlave
  import cfgSpiPkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SYNC_STAGES = 2,
  localparam int NREG = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdioIn,
  output logic              sdioOut,
  output logic              sdioOe,
  output logic              sdoOut,
  output logic              sdoOe,
  output logic [NREG*8-1:0] regFile
);

  logic [2:0]             syncd;
  logic                   csAct, sclkS, sdiS;
  cfgStrobe_t             strb;
  logic                   instrRead;
  logic [INSTR_CNT_W-1:0] instrCnt;
  logic                   outBit, lsbMode, bidirMode, readPhase;
  logic                   bitOutStb, frameStartStb;

  cfgSpiSync #(
    .STAGES(SYNC_STAGES),
    .WIDTH(3),
    .RESET_VAL(3'b100)
  ) u_sync (
    .clk(clk),
    .rstN(rstN),
    .asyncIn({csN, sclk, sdioIn}),
    .syncOut(syncd)
  );

  assign csAct = !syncd[2];
  assign sclkS = syncd[1];
  assign sdiS  = syncd[0];

  cfgSpiCtrl u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .csAct(csAct),
    .sclkS(sclkS),
    .instrRead(instrRead),
    .instrCnt(instrCnt),
    .strb(strb),
    .readPhase(readPhase)
  );

  cfgSpiData #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .sdiS(sdiS),
    .instrRead(instrRead),
    .instrCnt(instrCnt),
    .outBit(outBit),
    .lsbMode(lsbMode),
    .bidirMode(bidirMode),
    .regFlat(regFile)
  );

  assign bitOutStb     = strb.bitOut;
  assign frameStartStb = strb.frameStart;

  assign sdioOut = bidirMode ? outBit : 1'b0;
  assign sdoOut  = bidirMode ? 1'b0 : outBit;
  assign sdioOe  = bidirMode && readPhase;
  assign sdoOe   = !bidirMode && readPhase;

endmodule

// File: rtl/cfgSpiSlaveChk.sv
module cfgSpiSlaveChk #(
  parameter int NREG = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              csAct,
  input logic              bitOutStb,
  input logic              frameStartStb,
  input logic              sdoOut,
  input logic              sdoOe,
  input logic              sdioOe,
  input logic [NREG*8-1:0] regFile
);

  // R6: only one pin is ever driven
  p_pins_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(sdoOe && sdioOe));

  // R8: enables drop once chip select is released
  p_oe_released_r8: assert property (@(posedge clk) disable iff (!rstN)
    !csAct |=> (!sdoOe && !sdioOe));

  // R8: no register changes while not selected
  p_regs_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !csAct |=> $stable(regFile));

  // R5: read bit only moves after a falling-edge launch
  p_launch_on_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!bitOutStb && !frameStartStb) |=> $stable(sdoOut));

endmodule

bind cfgSpiSlave cfgSpiSlaveChk #(.NREG(NREG)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .csAct(csAct),
  .bitOutStb(bitOutStb),
  .frameStartStb(frameStartStb),
  .sdoOut(sdoOut),
  .sdoOe(sdoOe),
  .sdioOe(sdioOe),
  .regFile(regFile)
);

// File: tb/cfgSpiSlave_bench.sv
`timescale 1ns/1ps
module cfgSpiSlave_bench;

  localparam int NREG = 32;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdioIn = 1'b0;
  logic sdioOut, sdioOe, sdoOut, sdoOe;
  logic [NREG*8-1:0] regFile;

  logic [7:0] model [NREG];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfgSpiSlave u_cfgSpiSlave (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut), .sdoOe(sdoOe),
    .regFile(regFile)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [NREG*8-1:0] act, input logic [NREG*8-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NREG*8-1:0] packModel();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  // Shift nbits of b in the given order; sample the read pin before each rise
  task automatic xferByte(input logic [7:0] b, input bit lsb, input bit bidir,
                          input int nbits, input bit expOe, input string tag,
                          output logic [7:0] rd);
    rd = '0;
    for (int i = 0; i < nbits; i++) begin
      int idx;
      logic selOe, otherOe;
      idx = lsb ? i : 7 - i;
      sdioIn = b[idx];
      repeat (HALF) @(negedge clk);
      rd[idx] = bidir ? sdioOut : sdoOut;
      selOe   = bidir ? sdioOe : sdoOe;
      otherOe = bidir ? sdoOe : sdioOe;
      chk(selOe == expOe && !otherOe, tag, "output enable",
          {otherOe, selOe}, {1'b0, expOe});
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic doAccess(input bit rd, input logic [1:0] cnt, input logic [4:0] addr,
                          input int extra, input logic [7:0] wd [4], input string tag);
    bit lsb, bidir;
    logic [4:0] a;
    logic [7:0] got;
    lsb   = model[0][6];
    bidir = model[0][7];
    a     = addr;
    csN = 1'b0;
    repeat (4) @(negedge clk);
    xferByte({rd, cnt, addr}, lsb, bidir, 8, 1'b0, tag, got);
    for (int k = 0; k <= int'(cnt); k++) begin
      if (rd) begin
        xferByte(8'($urandom), lsb, bidir, 8, 1'b1, tag, got);
        chk(got == model[a], tag, "read byte", {248'd0, got}, {248'd0, model[a]});
      end else begin
        xferByte(wd[k], lsb, bidir, 8, 1'b0, tag, got);
        model[a] = wd[k];
      end
      a = lsb ? a + 5'd1 : a - 5'd1;
    end
    for (int e = 0; e < extra; e++) xferByte(8'($urandom), lsb, bidir, 8, 1'b0, "R7", got);
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (8) @(negedge clk);
    chk(regFile == packModel(), tag, "register file", regFile, packModel());
    chk(!sdoOe && !sdioOe, tag, "enables idle", {sdioOe, sdoOe}, 0);
  endtask

  // Frame cut short: instruction bits, then optionally part of a data byte
  task automatic abortAccess(input logic [7:0] instr, input int nInstr, input int nData);
    bit lsb, bidir;
    logic [7:0] got;
    lsb   = model[0][6];
    bidir = model[0][7];
    csN = 1'b0;
    repeat (4) @(negedge clk);
    xferByte(instr, lsb, bidir, nInstr, 1'b0, "R8", got);
    if (nData > 0) xferByte(8'h5A, lsb, bidir, nData, 1'b0, "R8", got);
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (8) @(negedge clk);
    chk(regFile == packModel(), "R8", "register file after abort", regFile, packModel());
    chk(!sdoOe && !sdioOe, "R8", "enables after abort", {sdioOe, sdoOe}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] wd [4];
    int seedDummy;
    seedDummy = $urandom(32'h5EED1234);
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    chk(regFile == '0, "R1", "registers after reset", regFile, '0);
    chk(!sdoOe && !sdioOe, "R1", "enables after reset", {sdioOe, sdoOe}, 0);
    wd = '{8'h00, 8'h00, 8'h00, 8'h00};
    doAccess(1'b1, 2'd1, 5'd5, 0, wd, "R1");

    // R3: highest bit first, address counts down and wraps 0 -> 31
    wd = '{8'hA5, 8'h3C, 8'h12, 8'h9E};
    doAccess(1'b0, 2'd3, 5'd2, 0, wd, "R3");
    doAccess(1'b1, 2'd3, 5'd2, 0, wd, "R3");

    // R2: single-byte read at the top address
    doAccess(1'b1, 2'd0, 5'd31, 0, wd, "R2");

    // R9: switch to lowest-bit-first mid access; second byte still MSB, down
    wd = '{8'h40, 8'h77, 8'h00, 8'h00};
    doAccess(1'b0, 2'd1, 5'd0, 0, wd, "R9");
    chk(regFile[31*8 +: 8] == 8'h77, "R9", "byte after mode write",
        {248'd0, regFile[31*8 +: 8]}, {248'd0, 8'h77});

    // R4: lowest bit first, address counts up and wraps 31 -> 0
    wd = '{8'hC3, 8'h5E, 8'h41, 8'h00};
    doAccess(1'b0, 2'd2, 5'd30, 0, wd, "R4");
    doAccess(1'b1, 2'd2, 5'd30, 0, wd, "R4");

    // R6: bidirectional read on the shared line
    wd = '{8'hC0, 8'h00, 8'h00, 8'h00};
    doAccess(1'b0, 2'd0, 5'd0, 0, wd, "R6");
    doAccess(1'b1, 2'd3, 5'd29, 0, wd, "R6");

    // R7: bytes past the count are ignored
    wd = '{8'hE7, 8'h00, 8'h00, 8'h00};
    doAccess(1'b0, 2'd0, 5'd7, 2, wd, "R7");
    doAccess(1'b1, 2'd0, 5'd7, 1, wd, "R7");

    // R8: aborts in the instruction and in a data byte
    abortAccess({1'b0, 2'd0, 5'd9}, 3, 0);
    abortAccess({1'b0, 2'd0, 5'd9}, 8, 5);
    wd = '{8'h3D, 8'h00, 8'h00, 8'h00};
    doAccess(1'b0, 2'd0, 5'd9, 0, wd, "R8");

    // R5: back to four-wire, highest-bit-first, then read on sdoOut
    wd = '{8'h00, 8'h00, 8'h00, 8'h00};
    doAccess(1'b0, 2'd0, 5'd0, 0, wd, "R5");
    doAccess(1'b1, 2'd2, 5'd9, 0, wd, "R5");

    // R10: random accesses in every mode
    for (int n = 0; n < 60; n++) begin
      bit rd;
      logic [1:0] cnt;
      logic [4:0] ad;
      int ex;
      rd  = 1'($urandom);
      cnt = 2'($urandom);
      ad  = 5'($urandom);
      ex  = ($urandom % 4 == 0) ? 1 : 0;
      for (int k = 0; k < 4; k++) wd[k] = 8'($urandom);
      doAccess(rd, cnt, ad, ex, wd, "R10");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule